// File: doc/BRIEF.md
# Audio master-clock ratio frame generator

This block runs on a free-running audio master clock and turns a 5-bit clocking setting into serial-port timing. The setting combines a rate mode with a ratio code. Together they fix how many master-clock cycles make up one audio frame.

From the active setting the block produces three outputs:
- a left/right frame strobe;
- a one-cycle bit-clock enable;
- a flag that reports whether a valid setting has ever been written.

A write that carries a reserved code is refused, and a sticky error flag records the attempt. A valid setting is first held as pending. It becomes active only at the next frame boundary, so no frame is ever cut short.

The block also holds the converter sample that belongs to the current frame. It captures one input word at every frame boundary. In high-rate mode it captures only every second frame, so each sample is sent in two successive frames. The sample output stays at zero until software has written a valid setting.

Top module: `clkratio_framegen`

## Requirements
- R1: After reset, `cfg_q` reads 5'b10000, which is ratio code 100 with rate mode 00 and gives a 512-cycle frame. `cfg_valid`, `cfg_err` and `smp_out` are all 0, and the frame counter starts at cycle 0.
- R2: Field layout: `cfg_wdata[1:0]` is the rate mode and `cfg_wdata[4:2]` is the ratio code.
  - In rate mode 00, ratio codes 000, 010, 011, 100 and 101 give frames of 128, 256, 384, 512 and 768 master-clock cycles.
  - Rate mode 01 halves each of these lengths.
  - Rate mode 10 quarters each of these lengths.
- R3: `lrck` is 0 during the first half of each frame and 1 during the second half.
- R4: The bit-clock divisor d is 2 for frames of up to 128 cycles, 4 for frames of up to 256, 8 for frames of up to 512, and 16 above that. `bclk_en` is 1 on the last cycle of each group of d cycles, counting from the start of the frame.
- R5: A write with rate mode 11, or with ratio code 001, 110 or 111, changes neither `cfg_q` nor the pending setting. It sets `cfg_err`, which then stays set until reset.
- R6: A valid write becomes visible on `cfg_q` only at the next frame boundary. A frame boundary is the cycle after the last cycle of a frame.
- R7: `cfg_valid` rises on the cycle after the first valid write and then stays high. While `cfg_valid` is 0, `smp_out` is 0.
- R8: On the last cycle of a frame, `smp_in` is captured into `smp_out`.
  - In rate modes 00 and 01 this happens every frame.
  - In rate mode 10 it happens only every second frame, so each sample is held across two frames.
  - The first frame after a change of setting always carries a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the clocking setting |
| cfg_wdata | input | 5 | Setting to write: [4:2] ratio code, [1:0] rate mode |
| cfg_q | output | 5 | Setting that is currently active |
| cfg_valid | output | 1 | A valid setting has been written |
| cfg_err | output | 1 | Sticky flag for a refused reserved write |
| lrck | output | 1 | Frame strobe (low = left half) |
| bclk_en | output | 1 | Bit-clock enable pulse |
| smp_in | input | DW | Converter sample to capture |
| smp_out | output | DW | Sample held for the current frame |

## Verification
The hardest case to reach is a change of setting that lands while high-rate mode is in the second, duplicated frame of a sample pair. The change must then force a fresh capture rather than keep the old sample for another frame. To reach it, the stimulus writes settings at random gaps of up to about two frame lengths, with the codes drawn from the full 5-bit space, so many writes arrive in the middle of frames and pending settings pile up. A directed run in high-rate mode is included as well. A cycle-by-cycle reference model in the bench checks every output at every cycle.

// File: rtl/clkratio_framegen.sv
module clkratio_framegen #(
  parameter int DW = 24
) (
  input  logic          mclk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_wdata,
  output logic [4:0]    cfg_q,
  output logic          cfg_valid,
  output logic          cfg_err,
  output logic          lrck,
  output logic          bclk_en,
  input  logic [DW-1:0] smp_in,
  output logic [DW-1:0] smp_out
);
  localparam int CW = 10;
  localparam logic [4:0] RST_CFG = 5'b10000;
  localparam logic [1:0] RATE_HI = 2'b10;

  function automatic logic [CW-1:0] frame_len(input logic [4:0] c);
    logic [CW-1:0] b;
    case (c[4:2])
      3'b000:  b = CW'(128);
      3'b010:  b = CW'(256);
      3'b011:  b = CW'(384);
      3'b100:  b = CW'(512);
      3'b101:  b = CW'(768);
      default: b = '0;
    endcase
    if (c[1:0] == 2'b11) b = '0;
    return b >> c[1:0];
  endfunction

  function automatic logic [3:0] bit_mask(input logic [CW-1:0] n);
    if (n <= CW'(128))      return 4'd1;
    else if (n <= CW'(256)) return 4'd3;
    else if (n <= CW'(512)) return 4'd7;
    else                    return 4'd15;
  endfunction

  logic [4:0]    act, pend;
  logic [CW-1:0] cnt, flen;
  logic [3:0]    msk;
  logic          par, wrap, wr_ok, cap;

  assign flen    = frame_len(act);
  assign msk     = bit_mask(flen);
  assign wrap    = (cnt == flen - CW'(1));
  assign wr_ok   = cfg_we && (frame_len(cfg_wdata) != '0);
  assign cap     = (pend != act) || (pend[1:0] != RATE_HI) || !par;
  assign cfg_q   = act;
  assign lrck    = (cnt >= (flen >> 1));
  assign bclk_en = ((cnt[3:0] & msk) == msk);

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      act       <= RST_CFG;
      pend      <= RST_CFG;
      cnt       <= '0;
      par       <= 1'b0;
      cfg_valid <= 1'b0;
      cfg_err   <= 1'b0;
      smp_out   <= '0;
    end else begin
      if (wr_ok) pend <= cfg_wdata;
      cfg_valid <= cfg_valid | wr_ok;
      cfg_err   <= cfg_err | (cfg_we & ~wr_ok);
      if (wrap) begin
        cnt <= '0;
        act <= pend;
        par <= (pend[1:0] == RATE_HI) && cap;
        if (cap) smp_out <= cfg_valid ? smp_in : '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R1
  initial_cfg_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_q == RST_CFG));

  // R2
  no_runt_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (flen != '0) && (cnt < flen));

  // R5
  err_sticky_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R6
  cfg_at_boundary_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(cfg_q));

  // R7
  valid_sticky_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    cfg_valid |=> cfg_valid);

  // R7
  muted_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !cfg_valid |-> (smp_out == '0));

  // R8
  hold_mid_frame_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(smp_out));
endmodule

// File: tb/sim_clkratio_framegen.sv
module sim_clkratio_framegen;
  localparam int DW = 24;

  logic          mclk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_wdata = '0;
  logic [4:0]    cfg_q;
  logic          cfg_valid, cfg_err, lrck, bclk_en;
  logic [DW-1:0] smp_in = '0;
  logic [DW-1:0] smp_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit run = 0;

  always #5 mclk = ~mclk;

  clkratio_framegen #(.DW(DW)) u0 (
    .mclk(mclk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .cfg_valid(cfg_valid), .cfg_err(cfg_err),
    .lrck(lrck), .bclk_en(bclk_en), .smp_in(smp_in), .smp_out(smp_out));

  // R2 frame-length table
  function automatic int exp_len(input logic [4:0] c);
    int b;
    case (c[4:2])
      3'b000: b = 128;
      3'b010: b = 256;
      3'b011: b = 384;
      3'b100: b = 512;
      3'b101: b = 768;
      default: b = 0;
    endcase
    if (c[1:0] == 2'b11) return 0;
    return b >> c[1:0];
  endfunction

  // R4 divisor rule
  function automatic int exp_div(input int n);
    if (n <= 128) return 2;
    if (n <= 256) return 4;
    if (n <= 512) return 8;
    return 16;
  endfunction

  logic [4:0]    m_act = 5'b10000, m_pend = 5'b10000;
  int            m_cnt = 0;
  bit            m_par = 0, m_val = 0, m_err = 0;
  logic [DW-1:0] m_out = '0;

  always @(posedge mclk) begin
    if (rst_n) begin
      automatic int n = exp_len(m_act);
      automatic bit ok = cfg_we && exp_len(cfg_wdata) != 0;
      if (ok) m_pend <= cfg_wdata;
      if (ok) m_val <= 1;
      if (cfg_we && !ok) m_err <= 1;
      if (m_cnt == n - 1) begin
        automatic bit c = (m_pend != m_act) || (m_pend[1:0] != 2'b10) || !m_par;
        m_cnt <= 0;
        m_act <= m_pend;
        m_par <= (m_pend[1:0] == 2'b10) && c;
        if (c) m_out <= m_val ? smp_in : '0;
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      if (errors < 20) $display("FAIL %s: actual %0h expected %0h (cycle %0d)", r, a, e, cyc);
    end
  endtask

  always @(negedge mclk) begin
    cyc++;
    if (run) begin
      automatic int n = exp_len(m_act);
      automatic int d = exp_div(n);
      chk("R6 cfg_q", 32'(cfg_q), 32'(m_act));
      chk("R3 lrck", 32'(lrck), 32'(m_cnt >= n / 2));
      chk("R4 bclk_en", 32'(bclk_en), 32'((m_cnt % d) == d - 1));
      chk("R7 cfg_valid", 32'(cfg_valid), 32'(m_val));
      chk("R5 cfg_err", 32'(cfg_err), 32'(m_err));
      chk("R8 smp_out", 32'(smp_out), 32'(m_out));
    end
  end

  always @(negedge mclk) smp_in <= DW'($urandom);

  task automatic wr(input logic [4:0] v);
    @(negedge mclk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge mclk);
    cfg_we = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge mclk);
    // R1 reset state
    chk("R1 cfg_q", 32'(cfg_q), 32'h10);
    chk("R1 cfg_valid", 32'(cfg_valid), 0);
    chk("R1 cfg_err", 32'(cfg_err), 0);
    chk("R1 smp_out", 32'(smp_out), 0);
    rst_n = 1'b1;
    run = 1;
    // R5 reserved ratio code, R7 still muted
    wr(5'b00100);
    chk("R5 err after reserved", 32'(cfg_err), 1);
    chk("R7 still invalid", 32'(cfg_valid), 0);
    repeat (600) @(negedge mclk);
    chk("R7 muted", 32'(smp_out), 0);
    // R5 reserved rate mode
    wr(5'b10011);
    // R6 high rate, ratio 100 -> 128 cycles
    wr(5'b10010);
    chk("R6 not yet active", 32'(cfg_q), 32'h10);
    repeat (1200) @(negedge mclk);
    chk("R2 high rate active", 32'(cfg_q), 32'h12);
    // R2 largest frame
    wr(5'b10100);
    repeat (1600) @(negedge mclk);
    // random mix of codes and gaps
    for (int i = 0; i < 150; i++) begin
      wr(5'($urandom));
      repeat ($urandom_range(1, 1200)) @(negedge mclk);
    end
    run = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mclk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule